// File: doc/BRIEF.md
# Programmable horizontal sync generator

This block produces a horizontal sync pulse for an 8-bit 4:2:2 component video byte stream of the ITU-R BT.656 kind, clocked at the pixel-bus rate. It watches the stream for the four-byte end-of-active-video timing code. An 11-bit position counter restarts on the clock after that code. The pulse is placed against this counter by two independent programmable edge positions.

Between timing codes the counter runs freely and wraps at the line length of the selected video standard. A pulse window can therefore wrap across the end of a line. A pulse is moved back, away from active video, by programming the line total minus the offset. A polarity control inverts the output.

All settings are taken into internal copies only when the counter restarts. A change in the middle of a line never produces a short pulse.

Top module: `hsync_gen`

## Requirements
- R1: On the clock edge that samples the last byte of a valid end-of-active-video code, the position counter becomes 0. The output for position p is visible in the cycle that follows the edge setting the counter to p.
- R2: The code is recognised only for the byte sequence FF, 00, 00, XY, where XY has bit 7 = 1 and bit 4 = 1. An FF byte always restarts matching. A sequence whose XY has bit 7 = 0 or bit 4 = 0 does not disturb the counter.
- R3: When start < end, the pulse is active exactly for positions start <= p < end.
- R4: When end <= start, the pulse is active for p >= start or p < end. With end == start, it is active over the whole line.
- R5: With no new code, the counter steps by 1 and wraps to 0 after position total-1. The line standard select std_sel_i gives the total: 0 = 1716, 1 = 1560, 2 = 1728, 3 = 1716.
- R6: With hs_inv_i = 0 the output is high while active. With hs_inv_i = 1 it is low while active.
- R7: Start, end, polarity and standard select are captured only when the counter restarts, either on a code or on a wrap. Changes between restarts have no effect on the output until the next restart.
- R8: Reset drives hs_o low and clears the counter. It loads start = 2, end = 0, non-inverted polarity and a line total of 1716.
- R9: A valid code arriving mid-line restarts the counter at once, overriding the free-running count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel-bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_i | input | 8 | Video byte stream |
| hs_start_i | input | 11 | Position where the pulse begins |
| hs_end_i | input | 11 | Position where the pulse ends |
| hs_inv_i | input | 1 | 1 = active-low output |
| std_sel_i | input | 2 | Line standard select (line total) |
| hs_o | output | 1 | Horizontal sync output |

## Verification
Short windows that lie fully inside a line show that the start and end edges are placed exactly. Windows that wrap, and equal start and end positions, separate the wrap-through interpretation from a plain comparison. Long runs with no timing code, one for each standard select value including the spare code, show that each line total is right, because any error in the total shifts every later position.

Code-like sequences with a bad XY byte are mixed into the stream to show that partial matches leave the count alone. A real code in mid-line shows that it overrides the count. Settings are changed mid-line to show they are held until the next restart. The reset defaults are seen as the pulse rising at position 2 before any code arrives.

// File: rtl/hsync_pkg.sv
package hsync_pkg;
  typedef enum logic [1:0] {
    TRS_IDLE = 2'd0,
    TRS_FF   = 2'd1,
    TRS_Z1   = 2'd2,
    TRS_Z2   = 2'd3
  } trs_st_e;

  typedef enum logic [1:0] {
    STD_525    = 2'd0,
    STD_525_SQ = 2'd1,
    STD_625    = 2'd2,
    STD_SPARE  = 2'd3
  } line_std_e;
endpackage

// File: rtl/hs_trs_detect.sv
module hs_trs_detect
  import hsync_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] pix_i,
  output logic              eav_o
);
  localparam int unsigned H_BIT = BYTE_W - 4;
  localparam logic [BYTE_W-1:0] ALL_ONE  = '1;
  localparam logic [BYTE_W-1:0] ALL_ZERO = '0;

  trs_st_e st_q, st_d;

  always_comb begin
    st_d = TRS_IDLE;
    if (pix_i == ALL_ONE) begin
      st_d = TRS_FF;
    end else begin
      unique case (st_q)
        TRS_FF:  st_d = (pix_i == ALL_ZERO) ? TRS_Z1 : TRS_IDLE;
        TRS_Z1:  st_d = (pix_i == ALL_ZERO) ? TRS_Z2 : TRS_IDLE;
        default: st_d = TRS_IDLE;
      endcase
    end
  end

  // XY must flag a timing code (msb) and the end-of-active side (H bit)
  assign eav_o = (st_q == TRS_Z2) && pix_i[BYTE_W-1] && pix_i[H_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= TRS_IDLE;
    else         st_q <= st_d;
  end

  a_r2_hit_spaced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eav_o |=> !eav_o);
  a_r2_hit_after_zeros: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eav_o |-> $past(pix_i) == ALL_ZERO);
endmodule

// File: rtl/hs_line_cnt.sv
module hs_line_cnt
  import hsync_pkg::*;
#(
  parameter int unsigned POS_W   = 11,
  parameter int unsigned TOT_525 = 1716,
  parameter int unsigned TOT_SQ  = 1560,
  parameter int unsigned TOT_625 = 1728
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             eav_i,
  input  logic [1:0]       std_sel_i,
  output logic             reload_o,
  output logic [POS_W-1:0] cnt_d_o
);
  localparam logic [POS_W-1:0] T_525 = POS_W'(TOT_525);
  localparam logic [POS_W-1:0] T_SQ  = POS_W'(TOT_SQ);
  localparam logic [POS_W-1:0] T_625 = POS_W'(TOT_625);

  logic [POS_W-1:0] cnt_q, tot_q, tot_sel;
  logic             at_last;

  always_comb begin
    unique case (line_std_e'(std_sel_i))
      STD_525_SQ: tot_sel = T_SQ;
      STD_625:    tot_sel = T_625;
      default:    tot_sel = T_525;
    endcase
  end

  assign at_last  = (cnt_q == tot_q - 1'b1);
  assign reload_o = eav_i || at_last;
  assign cnt_d_o  = reload_o ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tot_q <= T_525;
    end else begin
      cnt_q <= cnt_d_o;
      if (reload_o) tot_q <= tot_sel;
    end
  end

  a_r1_zero_after_eav: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eav_i |=> cnt_q == '0);
  a_r5_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!eav_i && cnt_q == tot_q - 1'b1) |=> cnt_q == '0);
  a_r5_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!eav_i && cnt_q != tot_q - 1'b1) |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r5_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < tot_q);
  a_r7_total_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reload_o |=> $stable(tot_q));
endmodule

// File: rtl/hs_pulse_shape.sv
module hs_pulse_shape #(
  parameter int unsigned POS_W     = 11,
  parameter int unsigned RST_START = 2,
  parameter int unsigned RST_STOP  = 0,
  parameter bit          RST_INV   = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reload_i,
  input  logic [POS_W-1:0] cnt_d_i,
  input  logic [POS_W-1:0] start_i,
  input  logic [POS_W-1:0] stop_i,
  input  logic             inv_i,
  output logic             hs_o
);
  logic [POS_W-1:0] start_q, stop_q, start_d, stop_d;
  logic             inv_q, inv_d, act_d, hs_q;

  function automatic logic in_window(input logic [POS_W-1:0] p,
                                     input logic [POS_W-1:0] s,
                                     input logic [POS_W-1:0] e);
    if (s < e) return (p >= s) && (p < e);
    return (p >= s) || (p < e);  // wraps through line end
  endfunction

  assign start_d = reload_i ? start_i : start_q;
  assign stop_d  = reload_i ? stop_i  : stop_q;
  assign inv_d   = reload_i ? inv_i   : inv_q;
  assign act_d   = in_window(cnt_d_i, start_d, stop_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= POS_W'(RST_START);
      stop_q  <= POS_W'(RST_STOP);
      inv_q   <= RST_INV;
      hs_q    <= RST_INV;
    end else begin
      start_q <= start_d;
      stop_q  <= stop_d;
      inv_q   <= inv_d;
      hs_q    <= act_d ^ inv_d;
    end
  end

  assign hs_o = hs_q;

  a_r7_shadow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reload_i |=> $stable(start_q) && $stable(stop_q) && $stable(inv_q));
  a_r4_full_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reload_i && start_q == stop_q) |=> hs_q == !inv_q);
endmodule

// File: rtl/hsync_gen.sv
module hsync_gen #(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned POS_W     = 11,
  parameter int unsigned TOT_525   = 1716,
  parameter int unsigned TOT_SQ    = 1560,
  parameter int unsigned TOT_625   = 1728,
  parameter int unsigned RST_START = 2,
  parameter int unsigned RST_STOP  = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] pix_i,
  input  logic [POS_W-1:0]  hs_start_i,
  input  logic [POS_W-1:0]  hs_end_i,
  input  logic              hs_inv_i,
  input  logic [1:0]        std_sel_i,
  output logic              hs_o
);
  logic             eav;
  logic             reload;
  logic [POS_W-1:0] cnt_d;

  hs_trs_detect #(.BYTE_W(BYTE_W)) i_trs (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pix_i (pix_i),
    .eav_o (eav)
  );

  hs_line_cnt #(
    .POS_W  (POS_W),
    .TOT_525(TOT_525),
    .TOT_SQ (TOT_SQ),
    .TOT_625(TOT_625)
  ) i_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .eav_i    (eav),
    .std_sel_i(std_sel_i),
    .reload_o (reload),
    .cnt_d_o  (cnt_d)
  );

  hs_pulse_shape #(
    .POS_W    (POS_W),
    .RST_START(RST_START),
    .RST_STOP (RST_STOP),
    .RST_INV  (1'b0)
  ) i_shape (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .reload_i(reload),
    .cnt_d_i (cnt_d),
    .start_i (hs_start_i),
    .stop_i  (hs_end_i),
    .inv_i   (hs_inv_i),
    .hs_o    (hs_o)
  );

  a_r8_idle_in_reset: assert property (@(posedge clk_i)
    !rst_ni |-> !hs_o);
endmodule

// File: tb/test_hsync_gen.sv
module test_hsync_gen;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  pix = 8'h80;
  logic [10:0] hs_start = 11'd100, hs_end = 11'd200;
  logic        hs_inv = 1'b1;
  logic [1:0]  std_sel = 2'd1;
  logic        hs;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  hsync_gen i_hsync_gen (
    .clk_i(clk), .rst_ni(rst_ni), .pix_i(pix),
    .hs_start_i(hs_start), .hs_end_i(hs_end), .hs_inv_i(hs_inv),
    .std_sel_i(std_sel), .hs_o(hs)
  );

  function automatic int line_total(input logic [1:0] sd);
    case (sd)
      2'd1:    return 1560;
      2'd2:    return 1728;
      default: return 1716;
    endcase
  endfunction

  function automatic logic exp_hs(input int p, input int s, input int e, input logic inv);
    logic act;
    if (s < e) act = (p >= s) && (p < e);
    else       act = (p >= s) || (p < e);
    return act ^ inv;
  endfunction

  task automatic check(input string req, input logic act, input logic exp, input int pos);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s pos=%0d hs_o=%b expected=%b", req, pos, act, exp);
    end
  endtask

  // Runs a stream: code at step 0..3; optional second code at ev2; optional bad code at bd.
  task automatic run(input string req,
                     input int sa, input int ea, input logic ia, input logic [1:0] da,
                     input int sb, input int eb, input logic ib, input logic [1:0] db,
                     input int sw, input int ev2, input int bd, input logic [7:0] bad_xy,
                     input int n);
    int   pos = 0;
    bit   valid = 1'b0;
    int   cs = sa, ce = ea;
    logic ci = ia;
    logic [1:0] cd = da;
    for (int k = 0; k < n; k++) begin
      bit eav_now;
      if (valid) check(req, hs, exp_hs(pos, cs, ce, ci), pos);
      if (k >= sw) begin
        hs_start = 11'(sb); hs_end = 11'(eb); hs_inv = ib; std_sel = db;
      end else begin
        hs_start = 11'(sa); hs_end = 11'(ea); hs_inv = ia; std_sel = da;
      end
      if (k < 4) pix = (k == 0) ? 8'hFF : (k == 3) ? 8'h9D : 8'h00;
      else if (ev2 >= 0 && k >= ev2 && k < ev2 + 4)
        pix = (k == ev2) ? 8'hFF : (k == ev2 + 3) ? 8'h9D : 8'h00;
      else if (bd >= 0 && k >= bd && k < bd + 4)
        pix = (k == bd) ? 8'hFF : (k == bd + 3) ? bad_xy : 8'h00;
      else pix = k[0] ? 8'h10 : 8'h80;
      @(posedge clk);
      eav_now = (k == 3) || (ev2 >= 0 && k == ev2 + 3);
      if (eav_now || (valid && pos == line_total(cd) - 1)) begin
        pos = 0; valid = 1'b1;
        cs = int'(hs_start); ce = int'(hs_end); ci = hs_inv; cd = std_sel;
      end else pos++;
      @(negedge clk);
    end
    pix = 8'h80;
  endtask

  task automatic t_reset_defaults;
    #1 check("R8 reset level", hs, 1'b0, 0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk); check("R8 default start pos1", hs, 1'b0, 1);
    @(negedge clk); check("R8 default start pos2", hs, 1'b1, 2);
    @(negedge clk); check("R8 default start pos3", hs, 1'b1, 3);
  endtask

  task automatic t_reset_mid;
    rst_ni = 1'b0;
    #1 check("R8 async reset inactive", hs, 1'b0, 0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_defaults();
    run("R1 R4 default window", 2, 0, 0, 2'd0, 2, 0, 0, 2'd0, 1 << 30, -1, -1, 8'h0, 40);
    run("R3 inner window", 10, 30, 0, 2'd0, 10, 30, 0, 2'd0, 1 << 30, -1, -1, 8'h0, 60);
    run("R4 R5 wrap window 525", 1700, 5, 0, 2'd0, 1700, 5, 0, 2'd0, 1 << 30, -1, -1, 8'h0, 1750);
    run("R6 inverted", 10, 30, 1, 2'd0, 10, 30, 1, 2'd0, 1 << 30, -1, -1, 8'h0, 60);
    t_reset_mid();
    run("R5 total 625", 1000, 1727, 0, 2'd2, 1000, 1727, 0, 2'd2, 1 << 30, -1, -1, 8'h0, 1760);
    run("R5 total square", 1550, 20, 0, 2'd1, 1550, 20, 0, 2'd1, 1 << 30, -1, -1, 8'h0, 1600);
    run("R5 spare select", 0, 1, 0, 2'd3, 0, 1, 0, 2'd3, 1 << 30, -1, -1, 8'h0, 1730);
    run("R4 equal edges", 40, 40, 0, 2'd0, 40, 40, 0, 2'd0, 1 << 30, -1, -1, 8'h0, 50);
    run("R2 bad xy no H", 90, 150, 0, 2'd0, 90, 150, 0, 2'd0, 1 << 30, -1, 100, 8'h80, 200);
    run("R2 bad xy no msb", 90, 150, 0, 2'd0, 90, 150, 0, 2'd0, 1 << 30, -1, 100, 8'h10, 200);
    run("R9 mid-line code", 250, 320, 0, 2'd0, 250, 320, 0, 2'd0, 1 << 30, 300, -1, 8'h0, 400);
    run("R7 held settings", 10, 30, 0, 2'd0, 50, 60, 1, 2'd2, 5, -1, -1, 8'h0, 1800);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule